// File: doc/BRIEF.md
# Address Window Decoder with Remap

This block sits on the CPU side of a bus bridge and turns each incoming 32-bit address into a routing decision. A bank of programmable general windows, plus one fixed window for the chip's internal register space, is compared against the address in parallel. The lowest-numbered window that matches supplies a target ID, an attribute byte and a translated 64-bit output address. The low-numbered windows can move the address to a different region and add upper address bits. The other windows pass the address through unchanged.

Software programs the windows through a simple word-addressed register port. Bits [1:0] of the port address select the register: 0 is control, 1 is base, 2 is remap-low and 3 is remap-high. The bits above them give the window index. General windows occupy indices 0 to NUM_WIN-1, and the internal-register window is index NUM_WIN. The match logic is combinational. Its result is captured into output registers one clock after `addr_valid`.

Top module: `addr_win_decoder`

## Requirements
- R1: After reset, every general window is disabled, all remap registers and general bases are zero, the internal-register window base reads 0xF100_0000, and `hit`, `miss` and all decode fields are zero.
- R2: The control register packs enable in bit 0, target ID in [7:4], attribute in [15:8] and size in [31:16], where the size field is the window size in 64 KB units minus one. Bits [3:1] read zero. Base and remap-low registers keep only bits [31:16] and read zero in [15:0].
- R3: A general window matches only when its enable bit is set and the address bits outside its mask ({size,16'hFFFF}) equal the same bits of its base.
- R4: When several windows match, the lowest index wins and its index appears on `win_idx`.
- R5: On a hit in window w < NUM_REMAP, `out_addr` is {remap-high, remap-low bits outside the mask, address bits inside the mask}.
- R6: Windows at or above NUM_REMAP give `out_addr` = {32'h0, addr}. Their remap registers read zero and ignore writes.
- R7: The internal-register window (index NUM_WIN) has only a base register and a fixed size of 1 MB. It is always enabled, yields target 0xF and attribute 0, passes the address through, and ranks below every general window. Its control register reads zero and ignores writes.
- R8: When no window matches a valid address, `miss` is 1 and `win_idx`, `tgt_id`, `attr` and `out_addr` are all zero. `hit` and `miss` are never both 1.
- R9: A register access to a window index above NUM_WIN is rejected: the write changes nothing and the read returns zero.
- R10: A register write takes effect on the following clock. A lookup presented in the same cycle as the write still sees the old contents.
- R11: `hit` or `miss` is 1 exactly in the cycle after a cycle with `addr_valid` high. While `addr_valid` is low, both are 0 on the next cycle and the decode fields hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_valid | input | 1 | Address on `addr` is to be decoded |
| addr | input | 32 | CPU address |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | IDX_W+2 (6) | {window index, register select} |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| hit | output | 1 | Registered: previous valid address matched |
| miss | output | 1 | Registered: previous valid address matched nothing |
| win_idx | output | IDX_W (4) | Index of the winning window |
| tgt_id | output | 4 | Target ID of the winning window |
| attr | output | 8 | Attribute byte of the winning window |
| out_addr | output | 64 | Translated address |

## Verification
Corrupted window state appears at the ports as a wrong `hit`/`miss` choice, a wrong `win_idx` or a wrong translated address. It shows on the cycle directly after the first lookup that falls into the affected region. A reference model steps alongside the design and compares every output on every clock, so a divergence is caught on the first cycle it becomes visible. Register state that no lookup touches, such as ignored remap writes and rejected indices, is read back through `reg_rdata` right after the write.

// File: rtl/awd_pkg.sv
package awd_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_BASE = 2'd1,
    SEL_RMLO = 2'd2,
    SEL_RMHI = 2'd3
  } awd_sel_e;

  localparam int TGT_W  = 4;
  localparam int ATTR_W = 8;
  localparam int UNIT_W = 16;
  localparam int OUT_W  = 64;
endpackage

// File: rtl/awd_win_regs.sv
module awd_win_regs
  import awd_pkg::*;
#(
  parameter int          NUM_WIN      = 8,
  parameter int          NUM_REMAP    = 4,
  parameter int          IDX_W        = 4,
  parameter logic [15:0] INT_BASE_RST = 16'hF100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  awd_sel_e          sel,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              en_o   [NUM_WIN],
  output logic [TGT_W-1:0]  tgt_o  [NUM_WIN],
  output logic [ATTR_W-1:0] attr_o [NUM_WIN],
  output logic [UNIT_W-1:0] size_o [NUM_WIN],
  output logic [UNIT_W-1:0] base_o [NUM_WIN+1],
  output logic [UNIT_W-1:0] rlo_o  [NUM_REMAP],
  output logic [31:0]       rhi_o  [NUM_REMAP]
);
  localparam int CTL_W = UNIT_W + ATTR_W + TGT_W + 1;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_ctrl
    logic             wr;
    logic [CTL_W-1:0] ctl_d, ctl_q;
    assign wr = we && (idx == IDX_W'(w)) && (sel == SEL_CTRL);
    always_comb ctl_d = {wdata[31:8], wdata[7:4], wdata[0]};
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  ctl_q <= '0;
      else if (wr) ctl_q <= ctl_d;
    end
    assign en_o[w]   = ctl_q[0];
    assign tgt_o[w]  = ctl_q[TGT_W:1];
    assign attr_o[w] = ctl_q[TGT_W+ATTR_W:TGT_W+1];
    assign size_o[w] = ctl_q[CTL_W-1:TGT_W+ATTR_W+1];
  end

  for (genvar w = 0; w <= NUM_WIN; w++) begin : g_base
    localparam logic [UNIT_W-1:0] RST = (w == NUM_WIN) ? INT_BASE_RST : '0;
    logic              wr;
    logic [UNIT_W-1:0] base_d, base_q;
    assign wr = we && (idx == IDX_W'(w)) && (sel == SEL_BASE);
    always_comb base_d = wdata[31:16];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  base_q <= RST;
      else if (wr) base_q <= base_d;
    end
    assign base_o[w] = base_q;
  end

  for (genvar r = 0; r < NUM_REMAP; r++) begin : g_remap
    logic              wr_lo, wr_hi;
    logic [UNIT_W-1:0] lo_d, lo_q;
    logic [31:0]       hi_d, hi_q;
    assign wr_lo = we && (idx == IDX_W'(r)) && (sel == SEL_RMLO);
    assign wr_hi = we && (idx == IDX_W'(r)) && (sel == SEL_RMHI);
    always_comb begin
      lo_d = wdata[31:16];
      hi_d = wdata;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lo_q <= '0;
        hi_q <= '0;
      end else begin
        if (wr_lo) lo_q <= lo_d;
        if (wr_hi) hi_q <= hi_d;
      end
    end
    assign rlo_o[r] = lo_q;
    assign rhi_o[r] = hi_q;
  end

  always_comb begin
    rdata = '0;
    for (int w = 0; w < NUM_WIN; w++)
      if (idx == IDX_W'(w) && sel == SEL_CTRL)
        rdata = {size_o[w], attr_o[w], tgt_o[w], 3'b000, en_o[w]};
    for (int w = 0; w <= NUM_WIN; w++)
      if (idx == IDX_W'(w) && sel == SEL_BASE)
        rdata = {base_o[w], 16'h0000};
    for (int r = 0; r < NUM_REMAP; r++) begin
      if (idx == IDX_W'(r) && sel == SEL_RMLO) rdata = {rlo_o[r], 16'h0000};
      if (idx == IDX_W'(r) && sel == SEL_RMHI) rdata = rhi_o[r];
    end
  end

  // R9
  oob_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idx > IDX_W'(NUM_WIN)) |-> (rdata == 32'h0));

  // R9
  oob_write_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && idx > IDX_W'(NUM_WIN)) |=> $stable(base_o[NUM_WIN]));
endmodule

// File: rtl/awd_win_match.sv
module awd_win_match
  import awd_pkg::*;
(
  input  logic              en,
  input  logic [UNIT_W-1:0] base,
  input  logic [UNIT_W-1:0] size,
  input  logic [31:0]       addr,
  output logic              hit,
  output logic [31:0]       mask
);
  always_comb begin
    mask = {size, 16'hFFFF};
    hit  = en && ((addr & ~mask) == ({base, 16'h0000} & ~mask));
  end
endmodule

// File: rtl/awd_prio_sel.sv
module awd_prio_sel #(
  parameter int N     = 9,
  parameter int IDX_W = 4
) (
  input  logic [N-1:0]     hits,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    any = |hits;
    idx = '0;
    for (int i = N - 1; i >= 0; i--)
      if (hits[i]) idx = IDX_W'(i);
  end
endmodule

// File: rtl/addr_win_decoder.sv
module addr_win_decoder
  import awd_pkg::*;
#(
  parameter int          NUM_WIN       = 8,
  parameter int          NUM_REMAP     = 4,
  parameter int          INT_SIZE_LOG2 = 20,
  parameter logic [3:0]  INT_TGT       = 4'hF,
  parameter logic [15:0] INT_BASE_RST  = 16'hF100,
  localparam int         IDX_W         = $clog2(NUM_WIN + 1),
  localparam int         RA_W          = IDX_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             addr_valid,
  input  logic [31:0]      addr,
  input  logic             reg_we,
  input  logic [RA_W-1:0]  reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  output logic             hit,
  output logic             miss,
  output logic [IDX_W-1:0] win_idx,
  output logic [3:0]       tgt_id,
  output logic [7:0]       attr,
  output logic [63:0]      out_addr
);
  localparam logic [UNIT_W-1:0] INT_SIZE_FIELD =
    UNIT_W'((32'd1 << (INT_SIZE_LOG2 - 16)) - 1);

  logic [IDX_W-1:0]  ridx;
  awd_sel_e          rsel;
  logic              en_w   [NUM_WIN];
  logic [TGT_W-1:0]  tgt_w  [NUM_WIN];
  logic [ATTR_W-1:0] attr_w [NUM_WIN];
  logic [UNIT_W-1:0] size_w [NUM_WIN];
  logic [UNIT_W-1:0] base_w [NUM_WIN+1];
  logic [UNIT_W-1:0] rlo_w  [NUM_REMAP];
  logic [31:0]       rhi_w  [NUM_REMAP];

  assign ridx = reg_addr[RA_W-1:2];
  assign rsel = awd_sel_e'(reg_addr[1:0]);

  awd_win_regs #(
    .NUM_WIN(NUM_WIN), .NUM_REMAP(NUM_REMAP), .IDX_W(IDX_W), .INT_BASE_RST(INT_BASE_RST)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .idx(ridx), .sel(rsel), .wdata(reg_wdata),
    .rdata(reg_rdata), .en_o(en_w), .tgt_o(tgt_w), .attr_o(attr_w), .size_o(size_w),
    .base_o(base_w), .rlo_o(rlo_w), .rhi_o(rhi_w)
  );

  logic [NUM_WIN:0]  hit_v;
  logic [31:0]       mask_v [NUM_WIN+1];
  logic [OUT_W-1:0]  xa_v   [NUM_WIN+1];
  logic [TGT_W-1:0]  tgt_v  [NUM_WIN+1];
  logic [ATTR_W-1:0] attr_v [NUM_WIN+1];

  for (genvar w = 0; w <= NUM_WIN; w++) begin : g_win
    if (w < NUM_WIN) begin : g_gen
      awd_win_match u_match (
        .en(en_w[w]), .base(base_w[w]), .size(size_w[w]), .addr(addr),
        .hit(hit_v[w]), .mask(mask_v[w])
      );
      assign tgt_v[w]  = tgt_w[w];
      assign attr_v[w] = attr_w[w];
    end else begin : g_int
      awd_win_match u_match (
        .en(1'b1), .base(base_w[w]), .size(INT_SIZE_FIELD), .addr(addr),
        .hit(hit_v[w]), .mask(mask_v[w])
      );
      assign tgt_v[w]  = INT_TGT;
      assign attr_v[w] = '0;
    end
    if (w < NUM_REMAP) begin : g_rm
      assign xa_v[w] = {rhi_w[w], ({rlo_w[w], 16'h0000} & ~mask_v[w]) | (addr & mask_v[w])};
    end else begin : g_pass
      assign xa_v[w] = {32'h0, addr};
    end
  end

  logic             any_hit;
  logic [IDX_W-1:0] pick;

  awd_prio_sel #(.N(NUM_WIN + 1), .IDX_W(IDX_W)) u_prio (
    .hits(hit_v), .any(any_hit), .idx(pick)
  );

  logic              hit_d, miss_d;
  logic [IDX_W-1:0]  idx_d;
  logic [TGT_W-1:0]  tgt_d;
  logic [ATTR_W-1:0] attr_d;
  logic [OUT_W-1:0]  xa_d;

  always_comb begin
    hit_d  = addr_valid & any_hit;
    miss_d = addr_valid & ~any_hit;
    idx_d  = '0;
    tgt_d  = '0;
    attr_d = '0;
    xa_d   = '0;
    for (int w = 0; w <= NUM_WIN; w++)
      if (any_hit && pick == IDX_W'(w)) begin
        idx_d  = pick;
        tgt_d  = tgt_v[w];
        attr_d = attr_v[w];
        xa_d   = xa_v[w];
      end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit      <= 1'b0;
      miss     <= 1'b0;
      win_idx  <= '0;
      tgt_id   <= '0;
      attr     <= '0;
      out_addr <= '0;
    end else begin
      hit  <= hit_d;
      miss <= miss_d;
      if (addr_valid) begin
        win_idx  <= idx_d;
        tgt_id   <= tgt_d;
        attr     <= attr_d;
        out_addr <= xa_d;
      end
    end
  end

  // R8
  hit_miss_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit && miss));

  // R8
  miss_fields_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miss |-> (tgt_id == '0 && attr == '0 && win_idx == '0 && out_addr == '0));

  // R11
  result_follows_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |=> (hit || miss));

  // R11
  no_result_without_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_valid |=> (!hit && !miss));

  // R7
  intreg_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && win_idx == IDX_W'(NUM_WIN)) |-> (tgt_id == INT_TGT && attr == '0 && out_addr[63:32] == '0));
endmodule

// File: tb/addr_win_decoder_bench.sv
`timescale 1ns/1ps
module addr_win_decoder_bench;
  localparam int NW = 8;
  localparam int NR = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        addr_valid;
  logic [31:0] addr;
  logic        reg_we;
  logic [5:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        hit, miss;
  logic [3:0]  win_idx, tgt_id;
  logic [7:0]  attr;
  logic [63:0] out_addr;

  addr_win_decoder u_addr_win_decoder (
    .clk(clk), .rst_n(rst_n), .addr_valid(addr_valid), .addr(addr),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .hit(hit), .miss(miss), .win_idx(win_idx), .tgt_id(tgt_id), .attr(attr), .out_addr(out_addr)
  );

  always #2.5 clk = ~clk;

  int    checks = 0;
  int    fails  = 0;
  bit    running = 0;
  string cur_req = "R1";

  logic        m_en   [NW];
  logic [3:0]  m_tgt  [NW];
  logic [7:0]  m_attr [NW];
  logic [15:0] m_size [NW];
  logic [15:0] m_base [NW+1];
  logic [15:0] m_rlo  [NR];
  logic [31:0] m_rhi  [NR];

  logic        e_hit, e_miss;
  logic [3:0]  e_idx, e_tgt;
  logic [7:0]  e_attr;
  logic [63:0] e_addr;

  task automatic model_reset();
    for (int w = 0; w < NW; w++) begin
      m_en[w] = 0; m_tgt[w] = 0; m_attr[w] = 0; m_size[w] = 0;
    end
    for (int w = 0; w <= NW; w++) m_base[w] = 0;
    m_base[NW] = 16'hF100;
    for (int r = 0; r < NR; r++) begin m_rlo[r] = 0; m_rhi[r] = 0; end
    e_hit = 0; e_miss = 0; e_idx = 0; e_tgt = 0; e_attr = 0; e_addr = 0;
  endtask

  task automatic model_decode(input logic [31:0] a);
    bit found = 0;
    e_idx = 0; e_tgt = 0; e_attr = 0; e_addr = 0;
    for (int w = 0; w <= NW; w++) begin
      logic [31:0] msk;
      logic        en;
      if (w < NW) begin msk = {m_size[w], 16'hFFFF}; en = m_en[w]; end
      else        begin msk = 32'h000F_FFFF;         en = 1'b1;     end
      if (!found && en && ((a & ~msk) == ({m_base[w], 16'h0} & ~msk))) begin
        found = 1;
        e_idx = 4'(w);
        if (w == NW) begin
          e_tgt = 4'hF; e_attr = 0; e_addr = {32'h0, a};
        end else begin
          e_tgt = m_tgt[w]; e_attr = m_attr[w];
          if (w < NR) e_addr = {m_rhi[w], ({m_rlo[w], 16'h0} & ~msk) | (a & msk)};
          else        e_addr = {32'h0, a};
        end
      end
    end
    e_hit = found; e_miss = !found;
  endtask

  task automatic model_write(input logic [5:0] ra, input logic [31:0] d);
    int i = int'(ra[5:2]);
    case (ra[1:0])
      2'd0: if (i < NW) begin
              m_en[i] = d[0]; m_tgt[i] = d[7:4]; m_attr[i] = d[15:8]; m_size[i] = d[31:16];
            end
      2'd1: if (i <= NW) m_base[i] = d[31:16];
      2'd2: if (i < NR) m_rlo[i] = d[31:16];
      default: if (i < NR) m_rhi[i] = d;
    endcase
  endtask

  function automatic logic [31:0] model_read(input logic [5:0] ra);
    int i = int'(ra[5:2]);
    case (ra[1:0])
      2'd0: return (i < NW) ? {m_size[i], m_attr[i], m_tgt[i], 3'b000, m_en[i]} : 32'h0;
      2'd1: return (i <= NW) ? {m_base[i], 16'h0} : 32'h0;
      2'd2: return (i < NR) ? {m_rlo[i], 16'h0} : 32'h0;
      default: return (i < NR) ? m_rhi[i] : 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else begin
      if (addr_valid) model_decode(addr);
      else begin e_hit = 0; e_miss = 0; end
      if (reg_we) model_write(reg_addr, reg_wdata);
    end
  end

  always @(negedge clk) begin
    if (rst_n && running) begin
      checks++;
      if (hit !== e_hit || miss !== e_miss || win_idx !== e_idx || tgt_id !== e_tgt ||
          attr !== e_attr || out_addr !== e_addr) begin
        fails++;
        $display("FAIL %s decode: hit=%0b/%0b miss=%0b/%0b idx=%0d/%0d tgt=%h/%h attr=%h/%h addr=%h/%h",
                 cur_req, hit, e_hit, miss, e_miss, win_idx, e_idx, tgt_id, e_tgt,
                 attr, e_attr, out_addr, e_addr);
      end
    end
  end

  task automatic cyc(input logic v, input logic [31:0] a, input logic w,
                     input logic [5:0] ra, input logic [31:0] wd);
    @(negedge clk);
    addr_valid = v; addr = a; reg_we = w; reg_addr = ra; reg_wdata = wd;
  endtask

  task automatic wr(input int i, input int s, input logic [31:0] d);
    cyc(0, 32'h0, 1, {4'(i), 2'(s)}, d);
  endtask

  task automatic look(input logic [31:0] a);
    cyc(1, a, 0, 6'h0, 32'h0);
  endtask

  task automatic idle();
    cyc(0, 32'h0, 0, 6'h0, 32'h0);
  endtask

  task automatic rd_chk(input int i, input int s, input string req);
    logic [31:0] exp;
    @(negedge clk);
    addr_valid = 0; reg_we = 0; reg_addr = {4'(i), 2'(s)};
    #1;
    exp = model_read(reg_addr);
    checks++;
    if (reg_rdata !== exp) begin
      fails++;
      $display("FAIL %s read win %0d sel %0d: got %h expected %h", req, i, s, reg_rdata, exp);
    end
  endtask

  function automatic logic [31:0] ctrlv(input logic [15:0] sz, input logic [7:0] at,
                                        input logic [3:0] tg, input logic en);
    return {sz, at, tg, 3'b000, en};
  endfunction

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 0; addr_valid = 0; addr = 0; reg_we = 0; reg_addr = 0; reg_wdata = 0;
    repeat (3) @(negedge clk);
    // R1 outputs held at zero while in reset
    checks++;
    if (hit !== 1'b0 || miss !== 1'b0 || out_addr !== 64'h0) begin
      fails++;
      $display("FAIL R1 reset outputs: got hit=%0b miss=%0b addr=%h expected 0 0 0", hit, miss, out_addr);
    end
    rst_n = 1;
    running = 1;
    // R1 register reset values
    rd_chk(0, 0, "R1");
    rd_chk(NW, 1, "R1");
    rd_chk(2, 2, "R1");

    // R2 R3 single 64 KB window
    cur_req = "R3";
    wr(0, 1, 32'h1000_ABCD);
    wr(0, 0, ctrlv(16'h0000, 8'h1E, 4'h2, 1'b1));
    rd_chk(0, 0, "R2");
    rd_chk(0, 1, "R2");
    look(32'h1000_1234);
    look(32'h1001_0000);
    look(32'h0FFF_FFFC);

    // R4 overlapping 1 MB window 1 loses to window 0
    cur_req = "R4";
    wr(1, 1, 32'h1000_0000);
    wr(1, 0, ctrlv(16'h000F, 8'h22, 4'h3, 1'b1));
    look(32'h1000_0008);
    look(32'h1008_0000);

    // R5 remap on window 2
    cur_req = "R5";
    wr(2, 1, 32'h2000_0000);
    wr(2, 2, 32'h5555_1234);
    wr(2, 3, 32'h0000_0007);
    wr(2, 0, ctrlv(16'h000F, 8'h40, 4'h5, 1'b1));
    rd_chk(2, 2, "R5");
    look(32'h200A_BCDE);
    look(32'h2010_0000);

    // R6 non-remap window 5 ignores remap writes
    cur_req = "R6";
    wr(5, 2, 32'h7777_0000);
    wr(5, 3, 32'hDEAD_BEEF);
    rd_chk(5, 2, "R6");
    rd_chk(5, 3, "R6");
    wr(5, 1, 32'h3000_0000);
    wr(5, 0, ctrlv(16'h0003, 8'h99, 4'h6, 1'b1));
    look(32'h3003_0010);

    // R3 disabled window never hits
    cur_req = "R3";
    wr(3, 1, 32'h4000_0000);
    wr(3, 0, ctrlv(16'h0000, 8'h11, 4'h7, 1'b0));
    look(32'h4000_0010);

    // R10 enable written in the same cycle as lookup: old value used
    cur_req = "R10";
    cyc(1, 32'h4000_0010, 1, {4'd3, 2'd0}, ctrlv(16'h0000, 8'h11, 4'h7, 1'b1));
    look(32'h4000_0010);

    // R7 internal window: fixed size, always enabled, ctrl ignored
    cur_req = "R7";
    look(32'hF10F_FFF0);
    look(32'hF110_0000);
    wr(NW, 0, 32'hFFFF_FFFF);
    rd_chk(NW, 0, "R7");
    wr(NW, 1, 32'hD000_0000);
    look(32'hF100_0004);
    look(32'hD000_0100);

    // R9 out-of-range window index
    cur_req = "R9";
    for (int i = NW + 1; i < 16; i++) begin
      wr(i, 1, 32'h1000_0000);
      wr(i, 0, ctrlv(16'h0000, 8'hAA, 4'h1, 1'b1));
      rd_chk(i, 0, "R9");
      rd_chk(i, 1, "R9");
    end
    look(32'h1000_0000);

    // R8 miss and R11 valid gaps
    cur_req = "R8";
    look(32'h9000_0000);
    cur_req = "R11";
    idle();
    look(32'h2000_0040);
    idle();
    idle();

    // mixed traffic
    cur_req = "R4";
    for (int n = 0; n < 400; n++) begin
      logic [31:0] pool [5];
      logic [31:0] a;
      pool[0] = 32'h1000_0000; pool[1] = 32'h2000_0000; pool[2] = 32'h3000_0000;
      pool[3] = 32'hD000_0000; pool[4] = 32'h4000_0000;
      a = pool[$urandom_range(0, 4)] | ($urandom & 32'h001F_FFFF);
      if ($urandom_range(0, 7) == 0) begin
        logic [5:0] ra;
        logic [31:0] d;
        ra = 6'($urandom_range(0, 63));
        d = (ra[1:0] == 2'd0) ? ctrlv(16'($urandom_range(0, 31)), 8'($urandom), 4'($urandom), 1'($urandom))
                              : pool[$urandom_range(0, 4)] | 32'($urandom_range(0, 3));
        cyc(1'($urandom), a, 1, ra, d);
      end else begin
        cyc(1'($urandom_range(0, 3) != 0), a, 0, 6'h0, 32'h0);
      end
    end
    idle();
    for (int i = 0; i < 16; i++) rd_chk(i, i % 4, "R2");
    idle();
    running = 0;
    finish_run();
  end
endmodule